// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB panel driven in dot-clock mode: horizontal sync, vertical sync, data-enable, a per-pixel request strobe with its column and row inside the visible area, and a one-cycle end-of-frame pulse. One pixel is timed per clock. Software-visible fields arrive as plain inputs: a packed horizontal control word (line length and hsync width), frame length, vsync width, the two back-porch waits counted from the end of each sync pulse, and the visible width and height.

Each line is laid out as the hsync pulse, then the horizontal back porch, then the visible pixels, then whatever is left of the line period. Frames follow the same layout in lines. Every panel signal has its own polarity input, and a separate output tells the pad logic which dot-clock edge should launch data. The pixel fetch path watches `pix_req` and the position outputs. The data path starts only once both the run and the sync-enable inputs are high.

Top module: `lcd_timing_gen`

## Requirements
- R1: During reset, `lcd_hsync`, `lcd_vsync` and `lcd_de` are 1 and every other output is 0. Whenever run or sync-enable is low, the position restarts at line 0, clock 0. One cycle later the three panel signals show their inactive levels (the inverse of their polarity inputs), and `pix_req`, `pix_x`, `pix_y`, `dclk_fall` and `frame_done` are 0.
- R2: With `run` high and `sync_on` low, nothing starts. The outputs stay idle exactly as in R1 for as long as `sync_on` stays low.
- R3: Each line lasts `line period` clocks. hsync is active during the first `hsync width` clocks of the line. All outputs are registered and show the position of the previous clock.
- R4: In the control word, bits [17:0] hold the line period. With VERSION 0 the hsync width is the 8-bit field at bits [31:24], and bits [23:18] are ignored. With VERSION 1 the hsync width is the 14-bit field at bits [31:18].
- R5: Each frame lasts `frame_lines` lines. vsync is active during the first `vsync_lines` lines of the frame.
- R6: Data-enable is active only where both windows hold. The horizontal window runs from clock hsync width + `h_porch` for `act_pixels` clocks. The vertical window runs from line `vsync_lines` + `v_porch` for `act_lines` lines. Both visible sizes must be at least MIN_ACT (120).
- R7: `pix_req` is high exactly in the data-enable cycles. `pix_x` and `pix_y` are then the zero-based column and row inside the visible area. Both are 0 when `pix_req` is low.
- R8: `frame_done` is a single-cycle pulse in the cycle right after the data-enable cycle of the last visible pixel of the last visible line.
- R9: `hs_high`, `vs_high` and `de_high` each make their signal active high when 1 and active low when 0.
- R10: `dclk_fall` follows `data_on_fall` one cycle later while the block runs. It is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Starts the data path |
| sync_on | input | 1 | Enables the sync outputs; required for running |
| hctl_word | input | WORD_W | Line period and hsync width, layout chosen by VERSION |
| frame_lines | input | FRAME_W | Lines per frame |
| vsync_lines | input | VSW_W | vsync width in lines |
| h_porch | input | HWAIT_W | Clocks from the end of hsync to the first visible pixel |
| v_porch | input | VWAIT_W | Lines from the end of vsync to the first visible line |
| act_pixels | input | ACT_W | Visible pixels per line |
| act_lines | input | ACT_W | Visible lines per frame |
| hs_high | input | 1 | hsync active high |
| vs_high | input | 1 | vsync active high |
| de_high | input | 1 | Data-enable active high |
| data_on_fall | input | 1 | Launch data on the falling dot-clock edge |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data-enable |
| dclk_fall | output | 1 | Edge select for the pad logic |
| pix_req | output | 1 | Pixel request strobe |
| pix_x | output | ACT_W | Visible column |
| pix_y | output | ACT_W | Visible row |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
With no front porch, both in the line and in the frame, the last visible pixel is also the last clock of the frame. The end-of-frame pulse must then land in the same cycle as the new frame's first hsync and vsync. The bench sets up such a mode with every polarity inverted. It compares every output on every clock against a behavioural position model. It also checks that the pulse was seen while hsync was active. A second instance built with the older field layout, and fed junk in the ignored bits, must match the same model.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;
   // width of the hsync field inside the horizontal control word
   function automatic int hsw_width(input int ver);
      return (ver == 0) ? 8 : 14;
   endfunction
   // lowest bit of the hsync field
   function automatic int hsw_lsb(input int ver);
      return (ver == 0) ? 24 : 18;
   endfunction
   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/lcdt_hword_split.sv
`timescale 1ns/1ps
module lcdt_hword_split #(
   parameter int VERSION = 1,
   parameter int WORD_W  = 32,
   parameter int PER_W   = 18,
   localparam int HSW_W  = lcdt_pkg::hsw_width(VERSION)
) (
   input  logic [WORD_W-1:0] word,
   output logic [PER_W-1:0]  period,
   output logic [HSW_W-1:0]  hsw
);
   logic unused_word_bits;
   assign unused_word_bits = ^word;
   assign period = word[PER_W-1:0];

   generate
      if (VERSION == 0) begin : g_narrow
         assign hsw = word[31:24];
      end else begin : g_wide
         assign hsw = word[31:18];
      end
   endgenerate
endmodule

// File: rtl/lcdt_axis_counter.sv
`timescale 1ns/1ps
module lcdt_axis_counter #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W:0] nxt;
   assign nxt  = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
   assign wrap = step && (nxt >= {1'b0, period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (wrap)   cnt <= '0;
      else if (step)   cnt <= nxt[W-1:0];
   end

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R1
   AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step && !wrap) |=> cnt == $past(cnt) + W'(1)); // R3
   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && wrap) |=> cnt == '0); // R5
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(cnt)); // R3
endmodule

// File: rtl/lcdt_window.sv
`timescale 1ns/1ps
module lcdt_window #(
   parameter int POS_W = 18,
   parameter int SW_W  = 14,
   parameter int WT_W  = 12,
   parameter int ACT_W = 16
) (
   input  logic [POS_W-1:0] pos,
   input  logic [SW_W-1:0]  sync_len,
   input  logic [WT_W-1:0]  porch,
   input  logic [ACT_W-1:0] act,
   output logic             in_sync,
   output logic             in_act,
   output logic             is_last,
   output logic [ACT_W-1:0] offset
);
   localparam int SUM_W = lcdt_pkg::max2(lcdt_pkg::max2(POS_W, SW_W),
                                         lcdt_pkg::max2(WT_W, ACT_W)) + 2;
   logic [SUM_W-1:0] p, s, first, stop;

   always_comb begin
      p       = SUM_W'(pos);
      s       = SUM_W'(sync_len);
      first   = s + SUM_W'(porch);
      stop    = first + SUM_W'(act);
      in_sync = p < s;
      in_act  = (p >= first) && (p < stop);
      is_last = (p + SUM_W'(1)) == stop;
      offset  = ACT_W'(p - first);
   end
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen #(
   parameter int VERSION = 1,
   parameter int WORD_W  = 32,
   parameter int PER_W   = 18,
   parameter int FRAME_W = 18,
   parameter int VSW_W   = 18,
   parameter int HWAIT_W = 12,
   parameter int VWAIT_W = 16,
   parameter int ACT_W   = 16,
   parameter int MIN_ACT = 120
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               sync_on,
   input  logic [WORD_W-1:0]  hctl_word,
   input  logic [FRAME_W-1:0] frame_lines,
   input  logic [VSW_W-1:0]   vsync_lines,
   input  logic [HWAIT_W-1:0] h_porch,
   input  logic [VWAIT_W-1:0] v_porch,
   input  logic [ACT_W-1:0]   act_pixels,
   input  logic [ACT_W-1:0]   act_lines,
   input  logic               hs_high,
   input  logic               vs_high,
   input  logic               de_high,
   input  logic               data_on_fall,
   output logic               lcd_hsync,
   output logic               lcd_vsync,
   output logic               lcd_de,
   output logic               dclk_fall,
   output logic               pix_req,
   output logic [ACT_W-1:0]   pix_x,
   output logic [ACT_W-1:0]   pix_y,
   output logic               frame_done
);
   localparam int HSW_W = lcdt_pkg::hsw_width(VERSION);
   localparam int HLSB  = lcdt_pkg::hsw_lsb(VERSION);

   generate
      if (VERSION != 0 && VERSION != 1) begin : g_bad_version
         $error("lcd_timing_gen: VERSION must be 0 or 1");
      end
      if (WORD_W < HLSB + HSW_W) begin : g_bad_word
         $error("lcd_timing_gen: control word too narrow for hsync field");
      end
      if (PER_W > HLSB) begin : g_bad_period
         $error("lcd_timing_gen: period field overlaps hsync field");
      end
      if (MIN_ACT >= (1 << ACT_W)) begin : g_bad_min
         $error("lcd_timing_gen: MIN_ACT does not fit ACT_W");
      end
   endgenerate

   logic               live;
   logic [PER_W-1:0]   line_per;
   logic [HSW_W-1:0]   hsw;
   logic [PER_W-1:0]   h_cnt;
   logic [FRAME_W-1:0] v_cnt;
   logic               h_wrap, v_wrap;
   logic               h_sync, h_act, h_last;
   logic               v_sync, v_act, v_last;
   logic [ACT_W-1:0]   h_off, v_off;
   logic               de_now, fd_pre;

   assign live = run && sync_on;

   lcdt_hword_split #(.VERSION(VERSION), .WORD_W(WORD_W), .PER_W(PER_W)) u_split (
      .word(hctl_word), .period(line_per), .hsw(hsw));

   lcdt_axis_counter #(.W(PER_W)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .clr(!live), .step(live),
      .period(line_per), .cnt(h_cnt), .wrap(h_wrap));

   lcdt_axis_counter #(.W(FRAME_W)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .clr(!live), .step(h_wrap),
      .period(frame_lines), .cnt(v_cnt), .wrap(v_wrap));

   lcdt_window #(.POS_W(PER_W), .SW_W(HSW_W), .WT_W(HWAIT_W), .ACT_W(ACT_W)) u_hwin (
      .pos(h_cnt), .sync_len(hsw), .porch(h_porch), .act(act_pixels),
      .in_sync(h_sync), .in_act(h_act), .is_last(h_last), .offset(h_off));

   lcdt_window #(.POS_W(FRAME_W), .SW_W(VSW_W), .WT_W(VWAIT_W), .ACT_W(ACT_W)) u_vwin (
      .pos(v_cnt), .sync_len(vsync_lines), .porch(v_porch), .act(act_lines),
      .in_sync(v_sync), .in_act(v_act), .is_last(v_last), .offset(v_off));

   logic unused_vwrap;
   assign unused_vwrap = v_wrap;

   assign de_now = live && h_act && v_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcd_hsync  <= 1'b1;
         lcd_vsync  <= 1'b1;
         lcd_de     <= 1'b1;
         dclk_fall  <= 1'b0;
         pix_req    <= 1'b0;
         pix_x      <= '0;
         pix_y      <= '0;
         fd_pre     <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         lcd_hsync  <= (live && h_sync) ? hs_high : !hs_high;
         lcd_vsync  <= (live && v_sync) ? vs_high : !vs_high;
         lcd_de     <= de_now ? de_high : !de_high;
         dclk_fall  <= live && data_on_fall;
         pix_req    <= de_now;
         pix_x      <= de_now ? h_off : '0;
         pix_y      <= de_now ? v_off : '0;
         fd_pre     <= de_now && h_last && v_last;
         frame_done <= fd_pre;
      end
   end

   AST_ACT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (act_pixels >= ACT_W'(MIN_ACT) && act_lines >= ACT_W'(MIN_ACT))); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> (!pix_req && lcd_de == !$past(de_high))); // R1
   AST_REQ_WITH_DE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |-> lcd_de == $past(de_high)); // R7
   AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && $past(pix_req) && pix_y == $past(pix_y)) |-> pix_x == $past(pix_x) + ACT_W'(1)); // R7
   AST_FD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R8
   AST_FD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(pix_req)); // R8
endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic run = 0, sync_on = 0, hs_high = 0, vs_high = 0, de_high = 0, data_on_fall = 0;
   int cfg_per = 140, cfg_hsw = 4, cfg_hp = 6, cfg_ap = 120;
   int cfg_fr = 128, cfg_vsw = 2, cfg_vp = 3, cfg_al = 120;

   logic [31:0] word_v1, word_v0;
   assign word_v1 = {14'(cfg_hsw), 18'(cfg_per)};
   assign word_v0 = {8'(cfg_hsw), 6'b101101, 18'(cfg_per)};

   logic hs1, vs1, de1, fa1, rq1, fd1;
   logic [15:0] x1, y1;
   logic hs0, vs0, de0, fa0, rq0, fd0;
   logic [15:0] x0, y0;

   lcd_timing_gen #(.VERSION(1)) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .sync_on(sync_on), .hctl_word(word_v1),
      .frame_lines(18'(cfg_fr)), .vsync_lines(18'(cfg_vsw)), .h_porch(12'(cfg_hp)),
      .v_porch(16'(cfg_vp)), .act_pixels(16'(cfg_ap)), .act_lines(16'(cfg_al)),
      .hs_high(hs_high), .vs_high(vs_high), .de_high(de_high), .data_on_fall(data_on_fall),
      .lcd_hsync(hs1), .lcd_vsync(vs1), .lcd_de(de1), .dclk_fall(fa1),
      .pix_req(rq1), .pix_x(x1), .pix_y(y1), .frame_done(fd1));

   lcd_timing_gen #(.VERSION(0)) dut_v0 (
      .clk(clk), .rst_n(rst_n), .run(run), .sync_on(sync_on), .hctl_word(word_v0),
      .frame_lines(18'(cfg_fr)), .vsync_lines(18'(cfg_vsw)), .h_porch(12'(cfg_hp)),
      .v_porch(16'(cfg_vp)), .act_pixels(16'(cfg_ap)), .act_lines(16'(cfg_al)),
      .hs_high(hs_high), .vs_high(vs_high), .de_high(de_high), .data_on_fall(data_on_fall),
      .lcd_hsync(hs0), .lcd_vsync(vs0), .lcd_de(de0), .dclk_fall(fa0),
      .pix_req(rq0), .pix_x(x0), .pix_y(y0), .frame_done(fd0));

   int n_cmp = 0, n_bad = 0;
   bit cmp_en = 0, done = 0;

   // behavioural reference: raster position as plain integers
   int mh = 0, mv = 0;
   bit e_hs = 1, e_vs = 1, e_de = 1, e_fall = 0, e_req = 0, e_fd = 0, fd_pend = 0;
   int e_x = 0, e_y = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_hs = 1; e_vs = 1; e_de = 1; e_fall = 0; e_req = 0; e_fd = 0;
         e_x = 0; e_y = 0; fd_pend = 0; mh = 0; mv = 0;
      end else begin
         e_fd = fd_pend;
         if (!(run && sync_on)) begin
            e_hs = !hs_high; e_vs = !vs_high; e_de = !de_high;
            e_req = 0; e_x = 0; e_y = 0; e_fall = 0; fd_pend = 0; mh = 0; mv = 0;
         end else begin
            int hs0p, vs0p;
            bit vis;
            hs0p = cfg_hsw + cfg_hp;
            vs0p = cfg_vsw + cfg_vp;
            vis  = (mh >= hs0p) && (mh < hs0p + cfg_ap) && (mv >= vs0p) && (mv < vs0p + cfg_al);
            e_hs = (mh < cfg_hsw) ? hs_high : !hs_high;
            e_vs = (mv < cfg_vsw) ? vs_high : !vs_high;
            e_de = vis ? de_high : !de_high;
            e_req = vis;
            e_x = vis ? mh - hs0p : 0;
            e_y = vis ? mv - vs0p : 0;
            e_fall = data_on_fall;
            fd_pend = vis && (mh == hs0p + cfg_ap - 1) && (mv == vs0p + cfg_al - 1);
            mh++;
            if (mh >= cfg_per) begin
               mh = 0;
               mv++;
               if (mv >= cfg_fr) mv = 0;
            end
         end
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         if (n_bad < 20)
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
      end
   endtask

   int fd_seen = 0;
   bit fd_with_sync = 0;

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         // R3, R9 hsync; R5, R9 vsync; R6, R9 de; R7 strobe; R8 end pulse; R10 edge
         check("R3,R9", "hsync", int'(hs1), int'(e_hs));
         check("R5,R9", "vsync", int'(vs1), int'(e_vs));
         check("R6,R9", "de", int'(de1), int'(e_de));
         check("R7", "pix_req", int'(rq1), int'(e_req));
         check("R7", "pix_x", int'(x1), e_x);
         check("R7", "pix_y", int'(y1), e_y);
         check("R8", "frame_done", int'(fd1), int'(e_fd));
         check("R10", "dclk_fall", int'(fa1), int'(e_fall));
         // R4: older layout instance must give the same raster
         check("R4", "v0 hsync", int'(hs0), int'(e_hs));
         check("R4", "v0 de", int'(de0), int'(e_de));
         check("R4", "v0 pix_x", int'(x0), e_x);
         check("R4", "v0 frame_done", int'(fd0), int'(e_fd));
         if (fd1) begin
            fd_seen++;
            if (hs1 == hs_high && vs1 == vs_high) fd_with_sync = 1;
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(3);
      // R1: reset values
      check("R1", "reset hsync", int'(hs1), 1);
      check("R1", "reset de", int'(de1), 1);
      check("R1", "reset pix_req", int'(rq1), 0);
      check("R1", "reset frame_done", int'(fd1), 0);
      cmp_en = 1;
      rst_n = 1;
      cycles(4);

      // R2: run without sync enable stays idle
      run = 1;
      cycles(200);
      check("R2", "idle hsync", int'(hs1), 1);
      check("R2", "idle pix_req", int'(rq1), 0);

      // config A: active-low, back porches present
      sync_on = 1;
      cycles(140 * 128 + 500);
      check("R8", "one pulse per frame A", fd_seen, 1);

      // R1: dropping run returns to idle levels
      run = 0;
      cycles(50);
      check("R1", "stopped de", int'(de1), 1);
      check("R1", "stopped pix_req", int'(rq1), 0);

      // config B: inverted polarities, no front porch anywhere
      cfg_per = 130; cfg_hsw = 10; cfg_hp = 0; cfg_ap = 120;
      cfg_fr = 121; cfg_vsw = 1; cfg_vp = 0; cfg_al = 120;
      hs_high = 1; vs_high = 1; de_high = 1; data_on_fall = 1;
      fd_seen = 0;
      cycles(3);
      check("R1,R9", "idle hsync inverted", int'(hs1), 0);
      run = 1;
      cycles(130 * 121 + 400);
      check("R8", "one pulse per frame B", fd_seen, 1);
      check("R8", "pulse with new-frame syncs", int'(fd_with_sync), 1);

      // stop mid-frame with inverted polarities
      run = 0;
      cycles(3);
      check("R1,R9", "stopped hsync inverted", int'(hs1), 0);
      check("R1,R10", "stopped dclk_fall", int'(fa1), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule